// File: doc/BRIEF.md
# Two-Phase Level-Encoded to Four-Phase Dual-Rail Receive Converter

This block sits at the receiving end of a global link that carries a multi-bit word in a level-encoded, two-phase form. Each bit travels on a pair of wires: a value rail and a parity rail. The bit's phase is the exclusive-OR of the two rails. The sender moves every bit into the next phase for each new word and never returns the wires to zero. The block watches all pairs until each one shows the phase it expects. It then hands the word to a local computation block over a four-phase, return-to-zero, dual-rail channel. Once the local side has taken the word and lowered its acknowledge again, the block flips the single link acknowledge wire.

The block is modelled as a clocked design. It has three states:
- `ST_WAIT`: waiting for a complete word.
- `ST_PRESENT`: the dual-rail word is on the outputs.
- `ST_SPACER`: all output rails are at zero.

It takes these transitions:
- `ST_WAIT`→`ST_PRESENT` when every bit matches the expected phase.
- `ST_PRESENT`→`ST_SPACER` when the local acknowledge is seen high.
- `ST_SPACER`→`ST_WAIT` when the local acknowledge is seen low. On this transition the link acknowledge toggles and the expected phase flips.

A timer raises a stall flag if the word sits part-way between phases for too long.

Top module: `ledr_rx_conv`

## Requirements
- R1: After reset the dual-rail outputs are all 00, `ch_ack` is 0, `stall` is 0, and the expected phase is odd (1). The idle all-zero line (even phase) is therefore not taken as a word.
- R2: A bit's phase is `ch_data[i] ^ ch_par[i]`. A word is accepted only on a clock edge where every bit's phase equals the expected phase. While any bit differs, the outputs stay 00.
- R3: One clock after the accepting edge, each pair (`dr_t[i]`,`dr_f[i]`) is (1,0) for `ch_data[i]`=1 and (0,1) for 0. The value comes from the data rail level alone. The word holds stable until the local acknowledge is seen.
- R4: No pair ever shows (1,1).
- R5: One clock after an edge in `ST_PRESENT` with `dr_ack`=1, every pair is 00.
- R6: `ch_ack` toggles exactly once per word, one clock after `dr_ack` is sampled low in `ST_SPACER`, and at no other time. The expected phase then alternates.
- R7: While `dr_ack` stays high, the outputs remain at the spacer and no new word is presented.
- R8: Inputs left at the phase of the word already consumed have no effect: the outputs stay 00 and `ch_ack` does not move.
- R9: In `ST_WAIT`, `stall` rises after `STALL_CYC` consecutive edges with mixed phases (some bits match, some do not). It falls one clock after the word completes.
- R10: The word width is the parameter `WIDTH` (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_data | input | WIDTH | Link value rails |
| ch_par | input | WIDTH | Link parity rails |
| ch_ack | output | 1 | Two-phase link acknowledge (toggles per word) |
| dr_t | output | WIDTH | Dual-rail true rails |
| dr_f | output | WIDTH | Dual-rail false rails |
| dr_ack | input | 1 | Four-phase acknowledge from the local block |
| stall | output | 1 | Mixed-phase timeout flag |

## Verification
The assertions assume the sender honours the handshake:
- It changes the rails only toward the next phase.
- It does not start a new word before `ch_ack` has toggled.

They also assume the local side raises `dr_ack` only while a word is shown and lowers it only after the spacer.

The bench keeps within these rules:
- It always moves a bit from the old phase to the new one.
- Staggered arrivals change a random subset of bits first and the rest later.
- It toggles `dr_ack` only in step with the observed outputs.
- It varies how long `dr_ack` is held high, and how long inputs linger at a consumed phase.

// File: rtl/ledr_rx_pkg.sv
package ledr_rx_pkg;
    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_PRESENT = 2'd1,
        ST_SPACER  = 2'd2
    } rx_state_t;
endpackage

// File: rtl/ledr_phase_chk.sv
module ledr_phase_chk #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic             exp_ph_i,
    output logic             all_hit_o,
    output logic             mixed_o
);
    logic [WIDTH-1:0] hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign hit[i] = ((data_i[i] ^ par_i[i]) == exp_ph_i);
    end

    assign all_hit_o = &hit;
    assign mixed_o   = (|hit) && !(&hit);
endmodule

// File: rtl/ledr_stall_tmr.sv
module ledr_stall_tmr #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed_i,
    output logic stall_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!armed_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stall_o = (cnt_q == CW'(LIMIT));

    // R9
    stall_needs_mixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> $past(armed_i));
endmodule

// File: rtl/ledr_dr_enc.sv
module ledr_dr_enc #(
    parameter int WIDTH = 8
) (
    input  logic             drive_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [WIDTH-1:0] t_o,
    output logic [WIDTH-1:0] f_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pair
        assign t_o[i] = drive_i &  word_i[i];
        assign f_o[i] = drive_i & ~word_i[i];
    end
endmodule

// File: rtl/ledr_rx_conv.sv
module ledr_rx_conv
    import ledr_rx_pkg::*;
#(
    parameter int WIDTH     = 8,
    parameter int STALL_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] ch_data,
    input  logic [WIDTH-1:0] ch_par,
    output logic             ch_ack,
    output logic [WIDTH-1:0] dr_t,
    output logic [WIDTH-1:0] dr_f,
    input  logic             dr_ack,
    output logic             stall
);
    rx_state_t        st_q, st_d;
    logic [WIDTH-1:0] word_q;
    logic             exp_q;
    logic             ack_q;
    logic             all_hit, mixed;
    logic             take_word, finish_word, drive;

    ledr_phase_chk #(.WIDTH(WIDTH)) u_phase (
        .data_i   (ch_data),
        .par_i    (ch_par),
        .exp_ph_i (exp_q),
        .all_hit_o(all_hit),
        .mixed_o  (mixed)
    );

    ledr_stall_tmr #(.LIMIT(STALL_CYC)) u_stall (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed_i(mixed && (st_q == ST_WAIT)),
        .stall_o(stall)
    );

    assign take_word   = (st_q == ST_WAIT)   && all_hit;
    assign finish_word = (st_q == ST_SPACER) && !dr_ack;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT:    if (all_hit) st_d = ST_PRESENT;
            ST_PRESENT: if (dr_ack)  st_d = ST_SPACER;
            ST_SPACER:  if (!dr_ack) st_d = ST_WAIT;
            default:    st_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_WAIT;
            word_q <= '0;
            exp_q  <= 1'b1;
            ack_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (take_word) begin
                word_q <= ch_data;
            end
            if (finish_word) begin
                ack_q <= ~ack_q;
                exp_q <= ~exp_q;
            end
        end
    end

    always_comb begin
        drive  = (st_q == ST_PRESENT);
        ch_ack = ack_q;
    end

    ledr_dr_enc #(.WIDTH(WIDTH)) u_enc (
        .drive_i(drive),
        .word_i (word_q),
        .t_o    (dr_t),
        .f_o    (dr_f)
    );

    // R4
    no_both_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dr_t & dr_f) == '0);

    // R6
    ack_toggle_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_ack != $past(ch_ack)) |-> ($past(st_q) == ST_SPACER && !$past(dr_ack)));

    // R5
    spacer_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRESENT && dr_ack) |=> (dr_t == '0 && dr_f == '0));

    // R2
    present_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRESENT && $past(st_q) == ST_WAIT) |-> $past(all_hit));

    // R3
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRESENT && $past(st_q) == ST_PRESENT) |-> ($stable(dr_t) && $stable(dr_f)));
endmodule

// File: tb/ledr_rx_conv_tb.sv
module ledr_rx_conv_tb;
    localparam int W     = 8;
    localparam int STALL = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ch_data = '0;
    logic [W-1:0] ch_par = '0;
    logic         ch_ack;
    logic [W-1:0] dr_t, dr_f;
    logic         dr_ack = 1'b0;
    logic         stall;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [W-1:0] cur_d = '0;
    logic [W-1:0] cur_p = '0;
    logic         ph = 1'b1;
    logic         ack_exp = 1'b0;

    always #5 clk = ~clk;

    ledr_rx_conv #(.WIDTH(W), .STALL_CYC(STALL)) u_dut (
        .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_par(ch_par),
        .ch_ack(ch_ack), .dr_t(dr_t), .dr_f(dr_f), .dr_ack(dr_ack), .stall(stall)
    );

    function automatic logic [W-1:0] par_for(input logic [W-1:0] v, input logic p);
        return v ^ {W{p}};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic chk_spacer(input string req);
        chk(dr_t == '0 && dr_f == '0, req, {dr_t, dr_f}, 0);
    endtask

    task automatic send_word(input logic [W-1:0] v, input int stagger, input int hold);
        logic [W-1:0] np, m;
        np = par_for(v, ph);
        if (stagger > 0) begin
            m = W'($urandom);
            if (m == '0 || m == '1) m = W'(1);
            ch_data = (v & m) | (cur_d & ~m);
            ch_par  = (np & m) | (cur_p & ~m);
            for (int k = 0; k < stagger; k++) begin
                @(negedge clk);
                chk_spacer("R2 mixed phase held off");
                chk(ch_ack == ack_exp, "R2 ack during mixed", ch_ack, ack_exp);
            end
        end
        ch_data = v;
        ch_par  = np;
        @(negedge clk);
        chk(dr_t == v && dr_f == ~v, "R3 dual-rail word", {dr_t, dr_f}, {v, ~v});
        chk(ch_ack == ack_exp, "R6 no early toggle", ch_ack, ack_exp);
        dr_ack = 1'b1;
        @(negedge clk);
        chk_spacer("R5 spacer after ack");
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            chk_spacer("R7 spacer while ack high");
            chk(ch_ack == ack_exp, "R7 ack stable", ch_ack, ack_exp);
        end
        dr_ack = 1'b0;
        @(negedge clk);
        ack_exp = ~ack_exp;
        chk(ch_ack == ack_exp, "R6 ack toggled", ch_ack, ack_exp);
        ph    = ~ph;
        cur_d = v;
        cur_p = np;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_spacer("R1 reset outputs");
        chk(ch_ack == 1'b0, "R1 reset ack", ch_ack, 0);
        chk(stall == 1'b0, "R1 reset stall", stall, 0);
        // R8 / R1: idle even-phase zeros not taken
        repeat (4) @(negedge clk);
        chk_spacer("R8 idle even phase ignored");
        chk(ch_ack == 1'b0, "R8 idle ack", ch_ack, 0);

        // directed corners
        send_word(8'h00, 0, 0);
        send_word(8'hFF, 0, 2);
        send_word(8'hA5, 3, 0);
        // R8: linger at consumed phase
        repeat (5) @(negedge clk);
        chk_spacer("R8 consumed phase ignored");
        chk(ch_ack == ack_exp, "R8 ack stable", ch_ack, ack_exp);

        // R9 stall timing
        begin
            logic [W-1:0] v, np;
            v  = 8'h3C;
            np = par_for(v, ph);
            ch_data = (v & 8'h0F) | (cur_d & 8'hF0);
            ch_par  = (np & 8'h0F) | (cur_p & 8'hF0);
            repeat (STALL - 1) @(negedge clk);
            chk(stall == 1'b0, "R9 no stall before limit", stall, 0);
            @(negedge clk);
            chk(stall == 1'b1, "R9 stall at limit", stall, 1);
            chk_spacer("R9 no output while stalled");
            ch_data = v;
            ch_par  = np;
            @(negedge clk);
            chk(stall == 1'b0, "R9 stall cleared", stall, 0);
            chk(dr_t == v && dr_f == ~v, "R9 word after stall", {dr_t, dr_f}, {v, ~v});
            dr_ack = 1'b1;
            @(negedge clk);
            dr_ack = 1'b0;
            @(negedge clk);
            ack_exp = ~ack_exp;
            chk(ch_ack == ack_exp, "R6 ack after stall word", ch_ack, ack_exp);
            ph = ~ph; cur_d = v; cur_p = np;
        end

        // R10 random words over the full WIDTH
        for (int n = 0; n < 60; n++) begin
            send_word(W'($urandom), int'($urandom_range(0, 4)), int'($urandom_range(0, 3)));
            if ($urandom_range(0, 3) == 0) begin
                repeat (2) @(negedge clk);
                chk_spacer("R8 idle between words");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule